// File: doc/BRIEF.md
# Pin Bank Output Multiplexer with Radio-State Values

This block drives a bank of 32 bidirectional pins from a small 32-bit register interface. The bank splits into a transmit-side half (pins 31:16) and a receive-side half (pins 15:0). Software sets an output value word, a direction word, and two per-pin source-choice words, one for each half. Each pin that is an output takes its level from one of four places: the software value bit, a radio-state word, or one of two debug buses.

The radio-state words sit in a separate bank of sixteen 32-bit slots. The first four slots hold one pin word for each activity state. The current pair of transmit and receive activity flags picks the slot, so the pins can follow the radio state with no software action. Reading the value word returns the sampled pad levels, not the stored output value.

The register interface is plain control: a write strobe, an address and write data, with read data taken combinationally from the address. There is no valid/ready handshake, because no streamed data passes through the block. Writes land on the next rising clock edge and are never back-pressured.

Top module: `gpio_atr_mux`

## Requirements
- R1: After reset, every register and every radio-state slot reads 0, `pad_oe` is all zeros and `pad_out` is all zeros.
- R2: Address 0 is the value word, 1 the direction word, 2 the transmit-half choice word and 3 the receive-half choice word. Address 16+k is radio-state slot k. Words at addresses 1, 2, 3 and 16 to 31 read back what was last written. Addresses 4 to 15 read 0, and writes to them change nothing.
- R3: `pad_oe` equals the direction word from the clock edge after it is written. Bit value 1 means output.
- R4: Any pin whose `pad_oe` bit is 0 has its `pad_out` bit at 0, whatever its choice code is.
- R5: Choice code 0 drives an output pin from the same bit of the stored value word.
- R6: Choice code 1 drives an output pin from the same bit of the radio-state word that is currently selected.
- R7: Choice code 2 drives an output pin from `dbg0`, and code 3 drives it from `dbg1`, bit for bit.
- R8: Transmit-half pin 16+k takes its code from bits 2k+1:2k of the word at address 2. Receive-half pin k takes its code from bits 2k+1:2k of the word at address 3.
- R9: The selected radio-state slot is {rx_active, tx_active}: 0 when idle, 1 for transmit only, 2 for receive only, 3 for both. The output follows a change of either flag in the same cycle.
- R10: Slots 4 to 15 store and read back data but have no effect on `pad_out`.
- R11: A read of address 0 returns `pad_in` as it was two rising edges earlier, through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe, acted on at the rising edge |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_active | input | 1 | Transmit activity flag |
| rx_active | input | 1 | Receive activity flag |
| dbg0 | input | 32 | Debug bus selected by code 2 |
| dbg1 | input | 32 | Debug bus selected by code 3 |
| pad_in | input | 32 | Sampled pad levels |
| pad_out | output | 32 | Pin output levels |
| pad_oe | output | 32 | Pin output enables, 1 drives the pad |

## Verification
The assertions assume that `reg_we`, `reg_addr` and `reg_wdata` are stable around each rising edge. They also assume that `reg_we` is low while reset is held, so the direction-follow check never compares against a write that reset overrode. The stimulus changes every input shortly after the falling edge and holds the write strobe low during reset, which keeps it inside these assumptions. The activity flags and debug buses are asynchronous to the register writes, so their checks compare only same-cycle combinational paths.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_ATR  = 2'd1,
    SRC_DBG0 = 2'd2,
    SRC_DBG1 = 2'd3
  } pin_src_e;

  localparam int REG_VALUE = 0;
  localparam int REG_DIR   = 1;
  localparam int REG_TXSEL = 2;
  localparam int REG_RXSEL = 3;
  localparam int NUM_STATES = 4;
endpackage

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
  import gpio_atr_pkg::*;
#(
  parameter int PINS       = 32,
  parameter int ATR_SLOTS  = 16,
  parameter int AW         = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [AW-1:0]                    addr,
  input  logic [PINS-1:0]                  wdata,
  input  logic [PINS-1:0]                  pad_in,
  output logic [PINS-1:0]                  rdata,
  output logic [PINS-1:0]                  value_q,
  output logic [PINS-1:0]                  dir_q,
  output logic [PINS-1:0]                  txsel_q,
  output logic [PINS-1:0]                  rxsel_q,
  output logic [NUM_STATES-1:0][PINS-1:0]  state_words
);
  localparam int SW = AW - 1;

  logic                              is_slot;
  logic [SW-1:0]                     idx;
  logic [ATR_SLOTS-1:0][PINS-1:0]    slot_q;
  logic [SYNC_DEPTH-1:0][PINS-1:0]   sync_q;

  assign is_slot = addr[AW-1];
  assign idx     = addr[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      dir_q   <= '0;
      txsel_q <= '0;
      rxsel_q <= '0;
      slot_q  <= '0;
    end else if (we) begin
      if (is_slot) begin
        slot_q[idx] <= wdata;
      end else begin
        case (int'(idx))
          REG_VALUE: value_q <= wdata;
          REG_DIR:   dir_q   <= wdata;
          REG_TXSEL: txsel_q <= wdata;
          REG_RXSEL: rxsel_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_DEPTH-2:0], pad_in};
  end

  always_comb begin
    rdata = '0;
    if (is_slot) begin
      rdata = slot_q[idx];
    end else begin
      case (int'(idx))
        REG_VALUE: rdata = sync_q[SYNC_DEPTH-1];
        REG_DIR:   rdata = dir_q;
        REG_TXSEL: rdata = txsel_q;
        REG_RXSEL: rdata = rxsel_q;
        default:   rdata = '0;
      endcase
    end
  end

  genvar s;
  generate
    for (s = 0; s < NUM_STATES; s++) begin : g_state
      assign state_words[s] = slot_q[s];
    end
  endgenerate
endmodule

// File: rtl/gpio_atr_state.sv
module gpio_atr_state
  import gpio_atr_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                            tx_active,
  input  logic                            rx_active,
  input  logic [NUM_STATES-1:0][PINS-1:0] state_words,
  output logic [PINS-1:0]                 atr_word
);
  logic [1:0] state_idx;

  assign state_idx = {rx_active, tx_active};
  assign atr_word  = state_words[state_idx];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_atr_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic [PINS-1:0] value_q,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] txsel_q,
  input  logic [PINS-1:0] rxsel_q,
  input  logic [PINS-1:0] atr_word,
  input  logic [PINS-1:0] dbg0,
  input  logic [PINS-1:0] dbg1,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  localparam int HALF = PINS / 2;

  assign pad_oe = dir_q;

  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_pin
      pin_src_e src;
      logic     lvl;
      if (p >= HALF) begin : g_tx
        assign src = pin_src_e'(txsel_q[2*(p-HALF) +: 2]);
      end else begin : g_rx
        assign src = pin_src_e'(rxsel_q[2*p +: 2]);
      end
      always_comb begin
        case (src)
          SRC_SW:   lvl = value_q[p];
          SRC_ATR:  lvl = atr_word[p];
          SRC_DBG0: lvl = dbg0[p];
          default:  lvl = dbg1[p];
        endcase
      end
      assign pad_out[p] = dir_q[p] & lvl;
    end
  endgenerate
endmodule

// File: rtl/gpio_atr_mux.sv
module gpio_atr_mux
  import gpio_atr_pkg::*;
#(
  parameter int PINS       = 32,
  parameter int ATR_SLOTS  = 16,
  parameter int SYNC_DEPTH = 2,
  localparam int AW        = $clog2(ATR_SLOTS) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [PINS-1:0] reg_wdata,
  output logic [PINS-1:0] reg_rdata,
  input  logic            tx_active,
  input  logic            rx_active,
  input  logic [PINS-1:0] dbg0,
  input  logic [PINS-1:0] dbg1,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  logic [PINS-1:0]                 value_q;
  logic [PINS-1:0]                 dir_q;
  logic [PINS-1:0]                 txsel_q;
  logic [PINS-1:0]                 rxsel_q;
  logic [NUM_STATES-1:0][PINS-1:0] state_words;
  logic [PINS-1:0]                 atr_word;

  gpio_atr_regs #(
    .PINS(PINS), .ATR_SLOTS(ATR_SLOTS), .AW(AW), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .pad_in(pad_in), .rdata(reg_rdata),
    .value_q(value_q), .dir_q(dir_q), .txsel_q(txsel_q),
    .rxsel_q(rxsel_q), .state_words(state_words)
  );

  gpio_atr_state #(.PINS(PINS)) u_state (
    .tx_active(tx_active), .rx_active(rx_active),
    .state_words(state_words), .atr_word(atr_word)
  );

  gpio_pin_mux #(.PINS(PINS)) u_mux (
    .value_q(value_q), .dir_q(dir_q), .txsel_q(txsel_q),
    .rxsel_q(rxsel_q), .atr_word(atr_word), .dbg0(dbg0), .dbg1(dbg1),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/gpio_atr_chk.sv
module gpio_atr_chk #(
  parameter int PINS = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic [PINS-1:0] reg_wdata,
  input logic [PINS-1:0] reg_rdata,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] dbg0,
  input logic [PINS-1:0] dbg1,
  input logic [PINS-1:0] rx_code
);
  // R2: the hole between the control words and the slot bank reads zero
  p_hole_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_addr[AW-1] && reg_addr >= AW'(4)) |-> reg_rdata == '0);

  // R3: enables take the direction word written on the previous edge
  p_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == AW'(1)) |-> pad_oe == $past(reg_wdata));

  // R4: an input pin never shows a high output level
  p_input_pin_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R7: receive pin 0 with code 2 mirrors debug bus 0
  p_pin0_dbg0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[0] && rx_code[1:0] == 2'd2) |-> pad_out[0] == dbg0[0]);

  // R7: receive pin 0 with code 3 mirrors debug bus 1
  p_pin0_dbg1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[0] && rx_code[1:0] == 2'd3) |-> pad_out[0] == dbg1[0]);
endmodule

bind gpio_atr_mux gpio_atr_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .dbg0(dbg0), .dbg1(dbg1), .rx_code(rxsel_q)
);

// File: tb/test_gpio_atr_mux.sv
`timescale 1ns/1ps
module test_gpio_atr_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_active = 1'b0;
  logic        rx_active = 1'b0;
  logic [31:0] dbg0 = '0;
  logic [31:0] dbg1 = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_atr_mux i_gpio_atr_mux (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_active(tx_active),
    .rx_active(rx_active), .dbg0(dbg0), .dbg1(dbg1), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // behavioural reference state
  logic [31:0] m_word [0:3];
  logic [31:0] m_slot [0:15];
  logic [31:0] m_pad_q [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_word[i] <= '0;
      for (int i = 0; i < 16; i++) m_slot[i] <= '0;
      m_pad_q = {32'h0, 32'h0};
    end else begin
      if (reg_we) begin
        if (reg_addr >= 16) m_slot[reg_addr - 16] <= reg_wdata;
        else if (reg_addr < 4) m_word[reg_addr] <= reg_wdata;
      end
      m_pad_q.push_back(pad_in);
      void'(m_pad_q.pop_front());
    end
  end

  function automatic logic [31:0] exp_out();
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      int code;
      code = (i >= 16) ? int'(m_word[2][2*(i-16) +: 2]) : int'(m_word[3][2*i +: 2]);
      if (m_word[1][i]) begin
        if (code == 0) r[i] = m_word[0][i];
        else if (code == 1) r[i] = m_slot[rx_active * 2 + tx_active][i];
        else if (code == 2) r[i] = dbg0[i];
        else r[i] = dbg1[i];
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    if (a >= 16) return m_slot[a - 16];
    if (a == 0) return m_pad_q[0];
    if (a < 4) return m_word[a];
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 pad_oe", pad_oe, m_word[1]);
      check("R4 R5 R6 R7 R8 R9 pad_out", pad_out, exp_out());
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk); #1;
    reg_we = 1'b0; reg_addr = 5'(a);
    #1 check(tag, reg_rdata, exp_read(a));
  endtask

  task automatic flags(bit t, bit r);
    @(negedge clk); #1;
    tx_active = t; rx_active = r;
    #1 check("R9 state pick", pad_out, exp_out());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pad_oe in reset", pad_oe, 32'h0);
    check("R1 pad_out in reset", pad_out, 32'h0);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 32; a++) rd(a, "R1 register clear");

    // software source, all outputs
    wr(1, 32'hFFFF_FFFF);
    wr(0, 32'hA5A5_5A5A);
    @(negedge clk); check("R5 value drive", pad_out, 32'hA5A5_5A5A);
    rd(1, "R2 dir readback");

    // radio-state source on every pin
    wr(16, 32'h1111_0001);
    wr(17, 32'h2222_0010);
    wr(18, 32'h4444_0100);
    wr(19, 32'h8888_1000);
    wr(2, 32'h5555_5555);
    wr(3, 32'h5555_5555);
    rd(2, "R2 tx code readback");
    flags(0, 0); flags(1, 0); flags(0, 1); flags(1, 1);
    @(negedge clk); check("R6 R9 both active", pad_out, 32'h8888_1000);

    // debug sources
    dbg0 = 32'hDEAD_BEEF; dbg1 = 32'h1357_9BDF;
    wr(2, 32'hAAAA_AAAA);
    wr(3, 32'hFFFF_FFFF);
    @(negedge clk); check("R7 debug buses", pad_out, 32'hDEAD_9BDF);
    // mixed codes per pin
    wr(2, 32'hE4E4_E4E4);
    wr(3, 32'h1B1B_1B1B);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      dbg0 = dbg0 ^ (32'h0F0F_0F0F << k); dbg1 = ~dbg1;
      tx_active = k[0]; rx_active = k[1];
      #1 check("R8 mixed codes", pad_out, exp_out());
    end

    // partial direction
    wr(1, 32'h0F0F_00FF);
    @(negedge clk); check("R4 inputs low", pad_out & ~pad_oe, 32'h0);

    // spare slots
    for (int s = 4; s < 16; s++) wr(16 + s, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) flags(k[0], k[1]);
    rd(27, "R10 spare slot readback");
    @(negedge clk); check("R10 spare slots no effect", pad_out, exp_out());

    // hole addresses
    wr(5, 32'hFFFF_FFFF);
    wr(12, 32'hFFFF_FFFF);
    rd(5, "R2 hole reads zero");
    rd(3, "R2 rx code unchanged");
    rd(1, "R2 dir unchanged");

    // synchronizer latency
    @(negedge clk); #1; reg_addr = 5'd0; pad_in = 32'hC0FF_EE11;
    @(negedge clk); #1 check("R11 one edge old", reg_rdata, 32'h0);
    @(negedge clk); #1 check("R11 two edges new", reg_rdata, 32'hC0FF_EE11);
    pad_in = 32'h0BAD_F00D;
    repeat (2) @(negedge clk);
    rd(0, "R11 second value");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule